// File: doc/BRIEF.md
# Power-Management Event Status and Clock Word Registers

This block is the register front end of a power-management unit. It keeps a small set of sticky event flags: power-on, the unlock of each of three PLLs, four interrupt sources and a software warm reset. Software clears each flag by writing a one to its bit. The same status word holds one enable per interrupt source. The interrupt line to the CPU is a level, the OR over all sources of pending AND enabled. Software can also request a warm reset through a write-one strobe.

A second register holds the clock-control word. Its six-bit field picks the system PLL frequency, which is the code times 1.8432 MHz, and one more bit picks the video PLL setting. A write carrying a system code outside the supported window is dropped. The event inputs are one-cycle pulses that outside logic has already debounced. The registers are reached over a plain synchronous bus: a write takes effect on the clock edge, and read data is combinational from the address.

Top module: `pmu_regs`

## Requirements
- R1: After the asynchronous reset `rstN`, the status word reads 0x0001 (only the power-on flag set), the clock word reads 0x001B, and `irqReq` and `warmRstReq` are low.
- R2: A status write (address 0) with a 1 in bit 0 clears the power-on flag. A 1 in bit 1, 2 or 3 clears the unlock flag of PLL 1, 2 or 3. A 0 in any of these bits leaves the flag as it was.
- R3: A pulse on `unlockPulse[i]` sets status bit 1+i, and a pulse on `irqPulse[j]` sets status bit 4+j. The set shows from the clock edge that samples the pulse.
- R4: A status write with a 1 in bits 4 to 7 clears the matching pending interrupt (sources 0 to 3). A 1 in bit 8 clears the warm-reset flag.
- R5: Status bits 12 to 9 are the enables of interrupt sources 3 to 0 (bit 9 is source 0). Every status write loads them from the written data, and they read back in place.
- R6: `irqReq` is high exactly while some source is both pending and enabled. Enabling a source that is already pending raises `irqReq` in the cycle after the write.
- R7: A status write with bit 13 set gives a one-cycle `warmRstReq` pulse in the following cycle and sets the warm-reset flag (bit 8). Bit 13 always reads 0, and a write with bit 13 at 0 requests nothing.
- R8: At address 1, bits 5:0 are the system PLL code (`sysPllCode`) and bit 6 is the video select (`vidPllSel`). A write is applied only when the code lies in 0x1B to 0x23. Otherwise the whole write is dropped and both fields keep their previous values.
- R9: An event pulse in the same cycle as a write that clears its flag wins, and the flag stays set.
- R10: Addresses 2 and 3 read as 0, and writes to them change no register and request no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 2 | Register address (0 status, 1 clock word) |
| busWdata | input | 14 | Write data |
| busRdata | output | 14 | Read data for `busAddr` |
| unlockPulse | input | 3 | One-cycle unlock events of PLL 1 to 3 |
| irqPulse | input | 4 | One-cycle interrupt events, sources 0 to 3 |
| irqReq | output | 1 | Level-sensitive interrupt to the CPU |
| warmRstReq | output | 1 | One-cycle warm reset request |
| sysPllCode | output | 6 | System PLL frequency code |
| vidPllSel | output | 1 | Video PLL frequency select |

## Verification
On every cycle the assertions check four things. An event pulse always leaves its flag set, even when a clear lands in the same cycle. A clear write without a competing event empties its flag. The interrupt line stays low while all enables are zero, and it rises right after a pending source is enabled. The system code never leaves its legal window, and a rejected clock write leaves both fields unchanged. Only the bench scenarios show the full status word as software reads it: the reset value, the enables reading back, that bit 13 reads 0, the silence of addresses 2 and 3, and the exact sequence of accepted and rejected clock words.

// File: rtl/pmu_regs_pkg.sv
package pmu_regs_pkg;
  parameter int NUM_PLL = 3;
  parameter int NUM_IRQ = 4;
  parameter int CODE_W  = 6;

  localparam int POR_BIT  = 0;
  localparam int PLL_LSB  = POR_BIT + 1;
  localparam int IRQ_LSB  = PLL_LSB + NUM_PLL;
  localparam int WARM_BIT = IRQ_LSB + NUM_IRQ;
  localparam int EN_LSB   = WARM_BIT + 1;
  localparam int RST_BIT  = EN_LSB + NUM_IRQ;
  localparam int STAT_W   = RST_BIT;
  localparam int DATA_W   = RST_BIT + 1;
  localparam int CTL_W    = CODE_W + 1;

  // strobes issued by the bus decoder to the register datapath
  typedef struct packed {
    logic               clrPor;
    logic [NUM_PLL-1:0] clrPll;
    logic [NUM_IRQ-1:0] clrIrq;
    logic               clrWarm;
    logic               enWr;
    logic [NUM_IRQ-1:0] enVal;
    logic               warmKick;
    logic               ctlWr;
  } strobe_t;
endpackage

// File: rtl/pmu_evt_flag.sv
// Sticky event flag: set has priority over clear.
module pmu_evt_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic setEvt,
  input  logic clrReq,
  output logic flagQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flagQ <= RST_VAL;
    else if (setEvt) flagQ <= 1'b1;
    else if (clrReq) flagQ <= 1'b0;
  end
endmodule

// File: rtl/pmu_ctrl.sv
// Bus decode: turns a write into the strobe struct.
module pmu_ctrl
  import pmu_regs_pkg::*;
#(
  parameter int                 ADDR_W    = 2,
  parameter logic [ADDR_W-1:0]  STAT_ADDR = '0,
  parameter logic [ADDR_W-1:0]  CTL_ADDR  = 1,
  parameter logic [CODE_W-1:0]  CODE_MIN  = 6'h1B,
  parameter logic [CODE_W-1:0]  CODE_MAX  = 6'h23
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strobe
);
  logic wrHit, statHit, ctlHit, codeOk;
  logic [CODE_W-1:0] newCode;

  always_comb begin
    wrHit   = busSel && busWr;
    statHit = wrHit && (busAddr == STAT_ADDR);
    ctlHit  = wrHit && (busAddr == CTL_ADDR);
    newCode = busWdata[CODE_W-1:0];
    codeOk  = (newCode >= CODE_MIN) && (newCode <= CODE_MAX);

    strobe.clrPor   = statHit && busWdata[POR_BIT];
    strobe.clrPll   = statHit ? busWdata[PLL_LSB +: NUM_PLL] : '0;
    strobe.clrIrq   = statHit ? busWdata[IRQ_LSB +: NUM_IRQ] : '0;
    strobe.clrWarm  = statHit && busWdata[WARM_BIT];
    strobe.enWr     = statHit;
    strobe.enVal    = busWdata[EN_LSB +: NUM_IRQ];
    strobe.warmKick = statHit && busWdata[RST_BIT];
    strobe.ctlWr    = ctlHit && codeOk;
  end
endmodule

// File: rtl/pmu_dp.sv
// Register datapath: event flags, enables, clock word, read mux.
module pmu_dp
  import pmu_regs_pkg::*;
#(
  parameter int                ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 1,
  parameter logic [CODE_W-1:0] CODE_RST  = 6'h1B
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [CTL_W-1:0]   ctlData,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_PLL-1:0] unlockPulse,
  input  logic [NUM_IRQ-1:0] irqPulse,
  output logic [DATA_W-1:0]  rdata,
  output logic [STAT_W-1:0]  statusQ,
  output logic               irqReq,
  output logic               warmRstReq,
  output logic [CODE_W-1:0]  sysPllCode,
  output logic               vidPllSel
);
  logic               porFlag, warmFlag;
  logic [NUM_PLL-1:0] pllFlag;
  logic [NUM_IRQ-1:0] irqPend;
  logic [NUM_IRQ-1:0] irqEn;

  pmu_evt_flag #(.RST_VAL(1'b1)) u_por (
    .clk(clk), .rstN(rstN), .setEvt(1'b0), .clrReq(strobe.clrPor), .flagQ(porFlag));

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    pmu_evt_flag #(.RST_VAL(1'b0)) u_flag (
      .clk(clk), .rstN(rstN), .setEvt(unlockPulse[g]),
      .clrReq(strobe.clrPll[g]), .flagQ(pllFlag[g]));
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    pmu_evt_flag #(.RST_VAL(1'b0)) u_flag (
      .clk(clk), .rstN(rstN), .setEvt(irqPulse[g]),
      .clrReq(strobe.clrIrq[g]), .flagQ(irqPend[g]));
  end

  pmu_evt_flag #(.RST_VAL(1'b0)) u_warm (
    .clk(clk), .rstN(rstN), .setEvt(strobe.warmKick),
    .clrReq(strobe.clrWarm), .flagQ(warmFlag));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn      <= '0;
      warmRstReq <= 1'b0;
      sysPllCode <= CODE_RST;
      vidPllSel  <= 1'b0;
    end else begin
      if (strobe.enWr) irqEn <= strobe.enVal;
      warmRstReq <= strobe.warmKick;
      if (strobe.ctlWr) {vidPllSel, sysPllCode} <= ctlData;
    end
  end

  assign statusQ = {irqEn, warmFlag, irqPend, pllFlag, porFlag};
  assign irqReq  = |(irqPend & irqEn);

  always_comb begin
    rdata = '0;
    if (busAddr == STAT_ADDR)     rdata[STAT_W-1:0] = statusQ;
    else if (busAddr == CTL_ADDR) rdata[CTL_W-1:0]  = {vidPllSel, sysPllCode};
  end
endmodule

// File: rtl/pmu_regs.sv
// Top: bus decoder plus register datapath.
module pmu_regs
  import pmu_regs_pkg::*;
#(
  parameter int                ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 1,
  parameter logic [CODE_W-1:0] CODE_MIN  = 6'h1B,
  parameter logic [CODE_W-1:0] CODE_MAX  = 6'h23,
  parameter logic [CODE_W-1:0] CODE_RST  = 6'h1B
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_PLL-1:0] unlockPulse,
  input  logic [NUM_IRQ-1:0] irqPulse,
  output logic               irqReq,
  output logic               warmRstReq,
  output logic [CODE_W-1:0]  sysPllCode,
  output logic               vidPllSel
);
  strobe_t             strobe;
  logic [STAT_W-1:0]   statusQ;

  pmu_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTL_ADDR(CTL_ADDR),
    .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
  ) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe));

  pmu_dp #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTL_ADDR(CTL_ADDR),
    .CODE_RST(CODE_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ctlData(busWdata[CTL_W-1:0]), .busAddr(busAddr),
    .unlockPulse(unlockPulse), .irqPulse(irqPulse),
    .rdata(busRdata), .statusQ(statusQ), .irqReq(irqReq),
    .warmRstReq(warmRstReq), .sysPllCode(sysPllCode), .vidPllSel(vidPllSel));
endmodule

// File: rtl/pmu_regs_chk.sv
module pmu_regs_chk
  import pmu_regs_pkg::*;
#(
  parameter int                ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 1,
  parameter logic [CODE_W-1:0] CODE_MIN  = 6'h1B,
  parameter logic [CODE_W-1:0] CODE_MAX  = 6'h23
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [NUM_PLL-1:0] unlockPulse,
  input logic [NUM_IRQ-1:0] irqPulse,
  input logic [STAT_W-1:0]  statusQ,
  input logic               irqReq,
  input logic               warmRstReq,
  input logic [CODE_W-1:0]  sysPllCode,
  input logic               vidPllSel
);
  logic wrStat, wrCtl, badCode;
  assign wrStat  = busSel && busWr && (busAddr == STAT_ADDR);
  assign wrCtl   = busSel && busWr && (busAddr == CTL_ADDR);
  assign badCode = (busWdata[CODE_W-1:0] < CODE_MIN) || (busWdata[CODE_W-1:0] > CODE_MAX);

  p_por_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrStat && busWdata[POR_BIT] |=> !statusQ[POR_BIT]);

  for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
    p_pll_set_r9: assert property (@(posedge clk) disable iff (!rstN)
      unlockPulse[i] |=> statusQ[PLL_LSB+i]);
    p_pll_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
      wrStat && busWdata[PLL_LSB+i] && !unlockPulse[i] |=> !statusQ[PLL_LSB+i]);
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    p_irq_set_r9: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse[i] |=> statusQ[IRQ_LSB+i]);
    p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
      wrStat && busWdata[IRQ_LSB+i] && !irqPulse[i] |=> !statusQ[IRQ_LSB+i]);
    p_enable_fires_r6: assert property (@(posedge clk) disable iff (!rstN)
      wrStat && busWdata[EN_LSB+i] && statusQ[IRQ_LSB+i] && !busWdata[IRQ_LSB+i]
      |=> irqReq);
  end

  p_enable_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStat |=> statusQ[EN_LSB +: NUM_IRQ] == $past(busWdata[EN_LSB +: NUM_IRQ]));

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[EN_LSB +: NUM_IRQ] == '0 |-> !irqReq);

  p_warm_kick_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrStat && busWdata[RST_BIT] |=> warmRstReq && statusQ[WARM_BIT]);

  p_warm_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    warmRstReq && !(wrStat && busWdata[RST_BIT]) |=> !warmRstReq);

  p_warm_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStat && busWdata[WARM_BIT] && !busWdata[RST_BIT] |=> !statusQ[WARM_BIT]);

  p_code_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sysPllCode >= CODE_MIN) && (sysPllCode <= CODE_MAX));

  p_bad_code_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl && badCode |=> $stable({vidPllSel, sysPllCode}));
endmodule

bind pmu_regs pmu_regs_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTL_ADDR(CTL_ADDR),
  .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .unlockPulse(unlockPulse), .irqPulse(irqPulse),
  .statusQ(statusQ), .irqReq(irqReq), .warmRstReq(warmRstReq),
  .sysPllCode(sysPllCode), .vidPllSel(vidPllSel));

// File: tb/pmu_regs_tb_top.sv
`timescale 1ns/1ps
module pmu_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [13:0] busWdata = '0;
  logic [13:0] busRdata;
  logic [2:0]  unlockPulse = '0;
  logic [3:0]  irqPulse = '0;
  logic        irqReq, warmRstReq, vidPllSel;
  logic [5:0]  sysPllCode;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pmu_regs dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .unlockPulse(unlockPulse),
    .irqPulse(irqPulse), .irqReq(irqReq), .warmRstReq(warmRstReq),
    .sysPllCode(sysPllCode), .vidPllSel(vidPllSel));

  // clock-word vectors: {write data, expected read-back}
  localparam logic [13:0] CTL_VEC [10][2] = '{
    '{14'h001C, 14'h001C},
    '{14'h0063, 14'h0063},
    '{14'h0024, 14'h0063},
    '{14'h001A, 14'h0063},
    '{14'h001B, 14'h001B},
    '{14'h003F, 14'h001B},
    '{14'h005E, 14'h005E},
    '{14'h0000, 14'h005E},
    '{14'h0023, 14'h0023},
    '{14'h0040, 14'h0023}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [13:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [13:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    logic [13:0] v;
    repeat (3) @(negedge clk);
    // R1 outputs during and after reset
    check("R1 irqReq", irqReq, 0);
    check("R1 warmRstReq", warmRstReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 sysPllCode", sysPllCode, 6'h1B);
    check("R1 vidPllSel", vidPllSel, 0);
    rd(2'd0, v); check("R1 status", v, 14'h0001);
    rd(2'd1, v); check("R1 clock word", v, 14'h001B);
    rd(2'd2, v); check("R10 addr2 read", v, 0);

    // R2 zeros leave flags; ones clear
    wr(2'd0, 14'h0000); rd(2'd0, v); check("R2 zero write", v, 14'h0001);
    wr(2'd0, 14'h0001); rd(2'd0, v); check("R2 por clear", v, 14'h0000);

    // R3 unlock events
    @(negedge clk); unlockPulse = 3'b101;
    @(negedge clk); unlockPulse = '0;
    rd(2'd0, v); check("R3 unlock set", v, 14'h000A);
    wr(2'd0, 14'h0002); rd(2'd0, v); check("R2 pll1 clear", v, 14'h0008);
    wr(2'd0, 14'h0008); rd(2'd0, v); check("R2 pll3 clear", v, 14'h0000);

    // R3/R6 interrupt events, masked
    @(negedge clk); irqPulse = 4'b0110;
    @(negedge clk); irqPulse = '0;
    rd(2'd0, v); check("R3 irq set", v, 14'h0060);
    check("R6 masked", irqReq, 0);
    wr(2'd0, 14'h0400); rd(2'd0, v); check("R5 enable readback", v, 14'h0460);
    check("R6 enable pending fires", irqReq, 1);
    wr(2'd0, 14'h0420); rd(2'd0, v); check("R4 irq1 clear", v, 14'h0440);
    check("R6 drops after clear", irqReq, 0);
    wr(2'd0, 14'h0800); check("R6 src2 enable", irqReq, 1);
    wr(2'd0, 14'h0000); rd(2'd0, v); check("R5 enables reloaded", v, 14'h0040);
    check("R6 disabled", irqReq, 0);
    wr(2'd0, 14'h0040); rd(2'd0, v); check("R4 irq2 clear", v, 14'h0000);

    // R9 event beats simultaneous clear
    @(negedge clk);
    irqPulse = 4'b0001; unlockPulse = 3'b001;
    busSel = 1'b1; busWr = 1'b1; busAddr = 2'd0; busWdata = 14'h0012;
    @(negedge clk);
    irqPulse = '0; unlockPulse = '0; busSel = 1'b0; busWr = 1'b0; busWdata = '0;
    rd(2'd0, v); check("R9 set wins", v, 14'h0012);
    wr(2'd0, 14'h0012); rd(2'd0, v); check("R9 later clear", v, 14'h0000);

    // R7 warm reset
    wr(2'd0, 14'h2000);
    check("R7 warm pulse", warmRstReq, 1);
    rd(2'd0, v); check("R7 warm flag, bit13 reads 0", v, 14'h0100);
    @(negedge clk); check("R7 single cycle", warmRstReq, 0);
    wr(2'd0, 14'h0100); rd(2'd0, v); check("R4 warm flag clear", v, 14'h0000);
    check("R7 zero write no request", warmRstReq, 0);

    // R10 unused addresses
    wr(2'd3, 14'h3FFF);
    check("R10 no warm request", warmRstReq, 0);
    rd(2'd0, v); check("R10 status untouched", v, 14'h0000);
    rd(2'd1, v); check("R10 clock untouched", v, 14'h001B);
    rd(2'd3, v); check("R10 addr3 read", v, 0);

    // R8 clock word table
    for (int k = 0; k < 10; k++) begin
      wr(2'd1, CTL_VEC[k][0]);
      rd(2'd1, v); check("R8 clock readback", v, CTL_VEC[k][1]);
      check("R8 sysPllCode", sysPllCode, CTL_VEC[k][1][5:0]);
      check("R8 vidPllSel", vidPllSel, CTL_VEC[k][1][6]);
    end

    // R1 reset again restores defaults
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(2'd1, v); check("R1 clock after re-reset", v, 14'h001B);
    rd(2'd0, v); check("R1 status after re-reset", v, 14'h0001);

    finishRun();
  end
endmodule